// File: doc/BRIEF.md
# Iterative Double-Word Normalizer

The block left-justifies a 31-bit signed integer held across two 16-bit registers, called A and B. The sign is the most significant bit of A. The 30 magnitude-side bits are the low 15 bits of A followed by the low 15 bits of B. The most significant bit of B takes no part in the value and passes through untouched. Bits are numbered MSB first, so bit 1 is the most significant bit of a word and bit 16 is the least significant.

After a start strobe the block shifts the 30-bit field left by one position per clock. A zero enters at the bottom. Shifting stops as soon as A bit 2 disagrees with the sign bit, A bit 1. The number of shifts is then written into key bits 9–16, which are the low 8 bits of the status word. The upper 8 key bits keep the values they had at start. This preserves the carry flag, the condition codes and the link bit held there.

An all-zero value is normalized without shifting and reports a count of 0. B bit 1 is ignored when the value is tested for zero. A one-cycle done strobe marks the cycle in which the final A, B and keys become valid. The outputs then hold those values until the next start.

Top module: `norm_dword_top`

## Requirements
- R1: While running, each clock moves the field {A[14:0], B[14:0]} left by exactly one position. B bit 2 (b[14]) enters A bit 16 (a[0]), and a 0 enters B bit 16 (b[0]).
- R2: A bit 1 (a[15]) and B bit 1 (b[15]) keep their start values through the whole operation.
- R3: Shifting stops as soon as a[14] differs from a[15]. A value that already satisfies this at start finishes with a count of 0 and unchanged A and B.
- R4: At done, keys_out[7:0] holds the shift count as an unsigned binary number. keys_out[15:8] equals keys_in[15:8] as sampled with the start strobe. keys_out does not change except at done.
- R5: A zero value (a == 0 and b[14:0] == 0, with b[15] ignored) finishes with a count of 0, unchanged A and B, and b[15] preserved.
- R6: The count never exceeds 30. The value -1 (all 31 value bits set) takes 30 shifts and ends as a = 16'h8000 with b[14:0] = 0.
- R7: With start sampled at clock edge E0, a run of k shifts raises done after edge E0+k+1.
- R8: A start strobe that arrives while an operation is in progress is ignored. The result is that of the operation already running.
- R9: done is high for exactly one cycle per operation. After done, a_out, b_out and keys_out hold their values until the next accepted start.
- R10: After synchronous reset, a_out, b_out and keys_out are 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation on a_in, b_in and keys_in (accepted only when idle) |
| a_in | input | 16 | Upper word of the value; bit 15 is the sign |
| b_in | input | 16 | Lower word; bit 15 is outside the value |
| keys_in | input | 16 | Status word whose upper byte is preserved |
| a_out | output | 16 | Upper word, shifted |
| b_out | output | 16 | Lower word, shifted |
| keys_out | output | 16 | Status word with the shift count in bits 7:0 |
| done | output | 1 | One-cycle strobe: outputs are final |

## Verification
On every cycle, the bound checker holds the design to several rules. The sign bits must stay fixed during a run, and the bottom bit must fill with zeros after each shift. done must never last more than one cycle, and keys_out must move only at done with its upper byte intact. Each finish must have a legal cause: the top two bits of A differ, the value is zero, or the count has reached 30. The exact shift count, the final bit pattern across the word boundary and the latency of k+1 edges after the start edge are shown only by the bench's directed scenarios. So are the handling of zero and -1 and the dropping of a start strobe mid-run, since each depends on the particular operand.

// File: rtl/norm_pkg.sv
package norm_pkg;

    localparam int WORD_W    = 16;
    localparam int CNT_W     = 8;
    localparam int LOW_W     = WORD_W - 1;
    localparam int MAG_W     = 2 * LOW_W;
    localparam int MAX_SHIFT = MAG_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } norm_state_e;

    // Value split into its two untouched top bits and the shiftable field.
    typedef struct packed {
        logic             sign_a;
        logic             spare_b;
        logic [MAG_W-1:0] field;
    } dword_t;

    typedef struct packed {
        logic load;
        logic shift_en;
        logic finish;
    } ctrl_t;

    function automatic dword_t pack_dword(input logic [WORD_W-1:0] a,
                                          input logic [WORD_W-1:0] b);
        dword_t d;
        d.sign_a  = a[WORD_W-1];
        d.spare_b = b[WORD_W-1];
        d.field   = {a[LOW_W-1:0], b[LOW_W-1:0]};
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] upper_word(input dword_t d);
        return {d.sign_a, d.field[MAG_W-1 -: LOW_W]};
    endfunction

    function automatic logic [WORD_W-1:0] lower_word(input dword_t d);
        return {d.spare_b, d.field[LOW_W-1:0]};
    endfunction

endpackage

// File: rtl/norm_shift_unit.sv
module norm_shift_unit
    import norm_pkg::*;
(
    input  dword_t cur,
    output dword_t nxt,
    output logic   is_norm,
    output logic   is_zero
);
    // Top bits fixed; field slides up one place with a zero at the bottom.
    always_comb begin
        nxt.sign_a  = cur.sign_a;
        nxt.spare_b = cur.spare_b;
        nxt.field   = {cur.field[MAG_W-2:0], 1'b0};
    end

    assign is_norm = cur.field[MAG_W-1] ^ cur.sign_a;
    assign is_zero = (~cur.sign_a) & ~(|cur.field);

endmodule

// File: rtl/norm_seq_ctrl.sv
module norm_seq_ctrl
    import norm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_norm,
    input  logic             is_zero,
    output ctrl_t            ctl,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(MAX_SHIFT);

    norm_state_e      state_q;
    logic [CNT_W-1:0] count_q;
    logic             done_q;
    logic             stop_now;

    assign stop_now = is_norm | is_zero | (count_q == CNT_LIMIT);

    always_comb begin
        ctl.load     = (state_q == ST_IDLE) && start;
        ctl.shift_en = (state_q == ST_RUN) && !stop_now;
        ctl.finish   = (state_q == ST_RUN) && stop_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        count_q <= '0;
                    end
                end
                ST_RUN: begin
                    if (stop_now) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        count_q <= count_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign count   = count_q;
    assign running = (state_q == ST_RUN);
    assign done    = done_q;

endmodule

// File: rtl/norm_keys_merge.sv
module norm_keys_merge
    import norm_pkg::*;
(
    input  logic [WORD_W-1:0] keys_hold,
    input  logic [CNT_W-1:0]  count,
    output logic [WORD_W-1:0] keys_next
);
    localparam logic [WORD_W-1:0] CNT_MASK = WORD_W'((1 << CNT_W) - 1);

    assign keys_next = (keys_hold & ~CNT_MASK) | WORD_W'(count);

endmodule

// File: rtl/norm_dword_top.sv
module norm_dword_top
    import norm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [WORD_W-1:0] keys_in,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] b_out,
    output logic [WORD_W-1:0] keys_out,
    output logic              done
);
    dword_t            val_q;
    dword_t            val_nxt;
    logic [WORD_W-1:0] keys_hold_q;
    logic [WORD_W-1:0] keys_q;
    logic [WORD_W-1:0] keys_merged;
    logic [CNT_W-1:0]  count;
    logic              is_norm;
    logic              is_zero;
    logic              running;
    ctrl_t             ctl;

    norm_shift_unit u_shift (
        .cur     (val_q),
        .nxt     (val_nxt),
        .is_norm (is_norm),
        .is_zero (is_zero)
    );

    norm_seq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .is_norm (is_norm),
        .is_zero (is_zero),
        .ctl     (ctl),
        .count   (count),
        .running (running),
        .done    (done)
    );

    norm_keys_merge u_keys (
        .keys_hold (keys_hold_q),
        .count     (count),
        .keys_next (keys_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q       <= '0;
            keys_hold_q <= '0;
            keys_q      <= '0;
        end else begin
            if (ctl.load) begin
                val_q       <= pack_dword(a_in, b_in);
                keys_hold_q <= keys_in;
            end else if (ctl.shift_en) begin
                val_q <= val_nxt;
            end
            if (ctl.finish) begin
                keys_q <= keys_merged;
            end
        end
    end

    assign a_out    = upper_word(val_q);
    assign b_out    = lower_word(val_q);
    assign keys_out = keys_q;

endmodule

// File: rtl/norm_dword_chk.sv
module norm_dword_chk
    import norm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              running,
    input logic [WORD_W-1:0] keys_in,
    input logic [WORD_W-1:0] a_out,
    input logic [WORD_W-1:0] b_out,
    input logic [WORD_W-1:0] keys_out,
    input logic              done
);
    localparam logic [WORD_W-1:0] HI_MASK   = ~WORD_W'((1 << CNT_W) - 1);
    localparam logic [CNT_W-1:0]  CNT_LIMIT = CNT_W'(MAX_SHIFT);

    logic [WORD_W-1:0] keys_cap_q;
    logic              val_zero;

    always_ff @(posedge clk) begin
        if (rst) keys_cap_q <= '0;
        else if (start && !running) keys_cap_q <= keys_in;
    end

    assign val_zero = (a_out == '0) && (b_out[LOW_W-1:0] == '0);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    sign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> ($stable(a_out[WORD_W-1]) && $stable(b_out[WORD_W-1])));

    // R1
    zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> (done || !b_out[0]));

    // R4
    keys_upper_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((keys_out & HI_MASK) == (keys_cap_q & HI_MASK)));

    // R4
    keys_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(keys_out));

    // R3
    stop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((a_out[WORD_W-1] != a_out[WORD_W-2]) ||
                  (val_zero && keys_out[CNT_W-1:0] == '0) ||
                  (keys_out[CNT_W-1:0] == CNT_LIMIT)));

    // R6
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (keys_out[CNT_W-1:0] <= CNT_LIMIT));

endmodule

bind norm_dword_top norm_dword_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .running  (running),
    .keys_in  (keys_in),
    .a_out    (a_out),
    .b_out    (b_out),
    .keys_out (keys_out),
    .done     (done)
);

// File: tb/norm_dword_top_tb_top.sv
module norm_dword_top_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] a_in, b_in, keys_in;
    logic [15:0] a_out, b_out, keys_out;
    logic        done;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    norm_dword_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .a_in     (a_in),
        .b_in     (b_in),
        .keys_in  (keys_in),
        .a_out    (a_out),
        .b_out    (b_out),
        .keys_out (keys_out),
        .done     (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bit-level model built from the requirements.
    task automatic model(input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] ea, output logic [15:0] eb,
                         output int n);
        logic [29:0] m;
        m = {a[14:0], b[14:0]};
        n = 0;
        if (m != 0) begin
            while (m[29] == a[15] && n < 30) begin
                m = {m[28:0], 1'b0};
                n++;
            end
        end
        ea = {a[15], m[29:15]};
        eb = {b[15], m[14:0]};
    endtask

    task automatic wait_done(output int cyc, output bit ok);
        cyc = 1;
        ok  = 1'b1;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc > 100) begin
                ok = 1'b0;
                break;
            end
        end
    endtask

    task automatic run_case(input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] k, input string req);
        logic [15:0] ea, eb;
        int n, cyc;
        bit ok;
        model(a, b, ea, eb, n);
        @(negedge clk);
        a_in = a; b_in = b; keys_in = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0; a_in = '0; b_in = '0; keys_in = '0;
        wait_done(cyc, ok);
        chk(ok, req, "done seen", 32'(ok), 32'd1);
        chk(a_out == ea, req, "a_out", 32'(a_out), 32'(ea));
        chk(b_out == eb, req, "b_out", 32'(b_out), 32'(eb));
        chk(keys_out == {k[15:8], 8'(n)}, "R4", "keys_out", 32'(keys_out),
            32'({k[15:8], 8'(n)}));
        chk(cyc == n + 2, "R7", "latency", 32'(cyc), 32'(n + 2));
        @(negedge clk);
        chk(!done, "R9", "done single pulse", 32'(done), 32'd0);
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; a_in = '0; b_in = '0; keys_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(a_out == 0 && b_out == 0, "R10", "value after reset",
            {a_out, b_out}, 32'd0);
        chk(keys_out == 0, "R10", "keys after reset", 32'(keys_out), 32'd0);
        chk(!done, "R10", "done after reset", 32'(done), 32'd0);
    endtask

    task automatic t_already_normal;
        run_case(16'h4000, 16'h1234, 16'hABCD, "R3");
        run_case(16'hA123, 16'hFFFF, 16'h00FF, "R3");
    endtask

    task automatic t_shift_paths;
        run_case(16'h0000, 16'h0001, 16'hC3FF, "R1");
        run_case(16'h0012, 16'h3456, 16'h1111, "R1");
        run_case(16'hFFF0, 16'h1234, 16'h7E00, "R1");
        run_case(16'h0000, 16'h8001, 16'h0000, "R2");
        run_case(16'h8000, 16'h8000, 16'h2200, "R2");
    endtask

    task automatic t_minus_one;
        run_case(16'hFFFF, 16'h7FFF, 16'h9900, "R6");
        chk(a_out == 16'h8000 && b_out == 16'h0000, "R6", "minus one result",
            {a_out, b_out}, 32'h8000_0000);
        chk(keys_out[7:0] == 8'd30, "R6", "count", 32'(keys_out[7:0]), 32'd30);
    endtask

    task automatic t_zero;
        run_case(16'h0000, 16'h8000, 16'h5A77, "R5");
        chk(b_out == 16'h8000 && keys_out == 16'h5A00, "R5", "zero keeps b sign",
            {b_out, keys_out}, 32'h8000_5A00);
    endtask

    task automatic t_busy_start;
        logic [15:0] ea, eb;
        int n, cyc;
        bit ok;
        model(16'h0000, 16'h0001, ea, eb, n);
        @(negedge clk);
        a_in = 16'h0000; b_in = 16'h0001; keys_in = 16'h3C00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        a_in = 16'h4000; b_in = 16'h0000; keys_in = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cyc, ok);
        chk(ok, "R8", "done seen", 32'(ok), 32'd1);
        chk(a_out == ea && b_out == eb, "R8", "result of first op",
            {a_out, b_out}, {ea, eb});
        chk(keys_out == {8'h3C, 8'(n)}, "R8", "keys of first op",
            32'(keys_out), 32'({8'h3C, 8'(n)}));
        chk(cyc + 4 == n + 2, "R8", "latency unchanged", 32'(cyc + 4), 32'(n + 2));
    endtask

    task automatic t_hold;
        logic [15:0] sa, sb, sk;
        run_case(16'h0003, 16'h0000, 16'h4400, "R9");
        sa = a_out; sb = b_out; sk = keys_out;
        repeat (6) begin
            @(negedge clk);
            chk(!done, "R9", "no extra done", 32'(done), 32'd0);
        end
        chk(a_out == sa && b_out == sb && keys_out == sk, "R9", "outputs held",
            {a_out, b_out}, {sa, sb});
    endtask

    initial begin
        #(200000 * 20);
        chk(1'b0, "WDOG", "watchdog expired", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_already_normal;
        t_shift_paths;
        t_minus_one;
        t_zero;
        t_busy_start;
        t_hold;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule